// File: doc/BRIEF.md
# Preemptive Interrupt Priority Resolver

The resolver keeps one priority byte for each of `NUM_SRC` interrupt sources. Only the upper `PRIO_BITS` bits of each byte are stored. The lower bits always read as zero, so software can learn how many bits exist by writing all ones and reading the byte back. A smaller numeric value is more urgent, and 0 is the most urgent value.

One global split setting divides every byte into two fields. The upper field is the preempting group. The lower field is a sub-priority that only orders requests that share a group. On every clock the block picks the most urgent source that is both pending and enabled. It then compares that source's group field with the group priority of the context that is running now. It raises a preempt request only when the pending group is strictly more urgent, or when the processor is at thread level with no handler active.

The configuration port maps the priority bytes and the split setting into one small address space. Reads of this port are registered.

Top module: `prio_resolver`

## Requirements
- R1: After synchronous reset, all stored priorities are 0, the split value is 0, and `preempt_req`, `win_idx`, `win_prio` and `cfg_rdata` are all 0.
- R2: A write to address `i < NUM_SRC` stores `cfg_wdata[7:8-PRIO_BITS]` for source `i`. Reading address `i` returns the stored bits in positions [7:8-PRIO_BITS], with zeros below them. A written 0xFF therefore reads back with ones only in the upper `PRIO_BITS` positions.
- R3: Address `NUM_SRC` holds the 3-bit split value n, taken from `cfg_wdata[2:0]`. It reads back as `{5'b0, n}`. In every priority byte, bits [7:n+1] form the group field and bits [n:0] form the sub-priority field.
- R4: Writes to an address above `NUM_SRC` change nothing, and reads of such an address return 0.
- R5: Only sources with both `src_pend[i]` and `src_en[i]` set take part. When no source qualifies, `preempt_req`, `win_idx` and `win_prio` are 0.
- R6: The winner is the qualifying source with the smallest full 8-bit priority value. When two sources have equal values, the lower index wins. `win_prio` carries the winner's 8-bit value.
- R7: All results and `cfg_rdata` are registered. They reflect the inputs and the stored configuration as they stood at the previous rising edge. A write takes effect from the edge after the one that stores it. A read at the same edge as a write to the same address returns the old value.
- R8: When `cur_thread` is 1, any qualifying source raises `preempt_req`.
- R9: When `cur_thread` is 0, `preempt_req` is 1 only if the winner's group field is strictly smaller than the group field of `cur_grp`. An equal group never preempts.
- R10: The sub-priority bits never change whether a preemption occurs. They only order sources whose group fields are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_SRC+1) | Configuration address: sources, then the split value |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read data for `cfg_addr` |
| src_pend | input | NUM_SRC | Pending flag for each source |
| src_en | input | NUM_SRC | Enable flag for each source |
| cur_thread | input | 1 | Running context is thread level, with no handler active |
| cur_grp | input | 8 | Priority of the running handler, as an 8-bit value |
| preempt_req | output | 1 | Winner may preempt the running context |
| win_idx | output | $clog2(NUM_SRC) | Index of the winning source |
| win_prio | output | 8 | 8-bit priority of the winning source |

## Verification
Every result, including `cfg_rdata`, is due exactly one rising edge after the stimulus that caused it. The bench drives its inputs on the falling edge. At the same moment it computes the expected results from its own copy of the configuration, using the values held before that edge. It then compares the outputs at the next falling edge. This also covers the case where a write lands on the same edge as an arbitration that uses the old value. Configuration changes made at an edge are applied to the model only after the expected values for that edge have been taken.

// File: rtl/prio_pkg.sv
package prio_pkg;

  // Group-field mask for split value n: bit b is in the group when b > n.
  function automatic logic [7:0] group_mask(input logic [2:0] n);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) begin
      m[b] = (b > int'(n));
    end
    return m;
  endfunction

  // Place stored priority bits at the top of an 8-bit value.
  function automatic logic [7:0] widen(input logic [7:0] stored_top);
    return stored_top;
  endfunction

endpackage

// File: rtl/prio_regfile.sv
module prio_regfile #(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 5,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [NUM_SRC*8-1:0]   prio_flat,
  output logic [2:0]             split,
  output logic [7:0]             rdata
);

  logic [PRIO_BITS-1:0] mem [NUM_SRC];
  logic [2:0]           split_q;
  logic                 hit_src;
  logic                 hit_split;
  logic [IDX_W-1:0]     slot;
  logic [7:0]           rd_src;
  logic                 unused_wbits;

  assign hit_src      = addr < ADDR_W'(NUM_SRC);
  assign hit_split    = addr == ADDR_W'(NUM_SRC);
  assign slot         = addr[IDX_W-1:0];
  assign unused_wbits = ^wdata;

  always_comb begin
    rd_src = '0;
    if (hit_src) begin
      rd_src[7 -: PRIO_BITS] = mem[slot];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        mem[i] <= '0;
      end
      split_q <= '0;
      rdata   <= '0;
    end else begin
      if (we && hit_src) begin
        mem[slot] <= wdata[7 -: PRIO_BITS];
      end
      if (we && hit_split) begin
        split_q <= wdata[2:0];
      end
      if (hit_src) begin
        rdata <= rd_src;
      end else if (hit_split) begin
        rdata <= {5'b0, split_q};
      end else begin
        rdata <= 8'h00;
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_expand
    logic [7:0] full;
    always_comb begin
      full = '0;
      full[7 -: PRIO_BITS] = mem[g];
    end
    assign prio_flat[g*8 +: 8] = full;
  end

  assign split = split_q;

endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]   qual,
  input  logic [NUM_SRC*8-1:0] prio_flat,
  output logic                 win_v,
  output logic [IDX_W-1:0]     win_i,
  output logic [7:0]           win_p
);

  logic [NUM_SRC:0] c_v;
  logic [7:0]       c_p [NUM_SRC+1];
  logic [IDX_W-1:0] c_i [NUM_SRC+1];

  assign c_v[0] = 1'b0;
  assign c_p[0] = 8'h00;
  assign c_i[0] = '0;

  // Linear chain: a later source replaces the holder only when strictly
  // more urgent, so equal values keep the lower index.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    logic [7:0] p_here;
    logic       take;
    assign p_here = prio_flat[g*8 +: 8];
    assign take   = qual[g] && (!c_v[g] || (p_here < c_p[g]));
    assign c_v[g+1] = c_v[g] | qual[g];
    assign c_p[g+1] = take ? p_here : c_p[g];
    assign c_i[g+1] = take ? IDX_W'(g) : c_i[g];
  end

  assign win_v = c_v[NUM_SRC];
  assign win_i = c_i[NUM_SRC];
  assign win_p = c_p[NUM_SRC];

endmodule

// File: rtl/preempt_gate.sv
module preempt_gate
  import prio_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_v,
  input  logic [IDX_W-1:0] win_i,
  input  logic [7:0]       win_p,
  input  logic [2:0]       split,
  input  logic             cur_thread,
  input  logic [7:0]       cur_grp,
  output logic             preempt_req,
  output logic [IDX_W-1:0] win_idx,
  output logic [7:0]       win_prio
);

  logic [7:0] mask;
  logic       urgent;
  logic       want;

  always_comb begin
    mask   = group_mask(split);
    urgent = (win_p & mask) < (cur_grp & mask);
    want   = win_v && (cur_thread || urgent);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preempt_req <= 1'b0;
      win_idx     <= '0;
      win_prio    <= 8'h00;
    end else begin
      preempt_req <= want;
      win_idx     <= win_v ? win_i : '0;
      win_prio    <= win_v ? win_p : 8'h00;
    end
  end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 4,
  localparam int ADDR_W   = $clog2(NUM_SRC + 1),
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic [NUM_SRC-1:0] src_pend,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               cur_thread,
  input  logic [7:0]         cur_grp,
  output logic               preempt_req,
  output logic [IDX_W-1:0]   win_idx,
  output logic [7:0]         win_prio
);

  logic [NUM_SRC*8-1:0] prio_flat;
  logic [2:0]           cfg_split;
  logic [NUM_SRC-1:0]   qual;
  logic                 arb_v;
  logic [IDX_W-1:0]     arb_i;
  logic [7:0]           arb_p;

  assign qual = src_pend & src_en;

  prio_regfile #(
    .NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .prio_flat(prio_flat), .split(cfg_split), .rdata(cfg_rdata)
  );

  prio_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .qual(qual), .prio_flat(prio_flat),
    .win_v(arb_v), .win_i(arb_i), .win_p(arb_p)
  );

  preempt_gate #(.IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst(rst), .win_v(arb_v), .win_i(arb_i), .win_p(arb_p),
    .split(cfg_split), .cur_thread(cur_thread), .cur_grp(cur_grp),
    .preempt_req(preempt_req), .win_idx(win_idx), .win_prio(win_prio)
  );

endmodule

module prio_resolver_chk
  import prio_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 4,
  parameter int IDX_W     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_pend,
  input logic [NUM_SRC-1:0] src_en,
  input logic               cur_thread,
  input logic [7:0]         cur_grp,
  input logic [2:0]         split,
  input logic [7:0]         cfg_rdata,
  input logic               preempt_req,
  input logic [IDX_W-1:0]   win_idx,
  input logic [7:0]         win_prio
);

  logic [NUM_SRC-1:0] qual_d;
  logic               thr_d;
  logic [7:0]         grp_d;
  logic [2:0]         split_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_d  <= '0;
      thr_d   <= 1'b0;
      grp_d   <= 8'h00;
      split_d <= 3'd0;
    end else begin
      qual_d  <= src_pend & src_en;
      thr_d   <= cur_thread;
      grp_d   <= cur_grp;
      split_d <= split;
    end
  end

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((src_pend & src_en) == '0) |=> (!preempt_req && win_idx == '0 && win_prio == 8'h00));

  // R8
  thread_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_thread && ((src_pend & src_en) != '0)) |=> preempt_req);

  // R6
  winner_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_d != '0) |-> qual_d[win_idx]);

  // R9
  strict_group_chk: assert property (@(posedge clk) disable iff (rst)
    (preempt_req && !thr_d) |-> ((win_prio & group_mask(split_d)) < (grp_d & group_mask(split_d))));

  // R2
  if (PRIO_BITS < 8) begin : g_low
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
      win_prio[7-PRIO_BITS:0] == '0);
  end

endmodule

bind prio_resolver prio_resolver_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .src_pend(src_pend), .src_en(src_en),
  .cur_thread(cur_thread), .cur_grp(cur_grp), .split(cfg_split),
  .cfg_rdata(cfg_rdata), .preempt_req(preempt_req), .win_idx(win_idx),
  .win_prio(win_prio)
);

// File: tb/prio_resolver_bench.sv
module prio_resolver_bench;

  localparam int N      = 16;
  localparam int P      = 4;
  localparam int AW     = $clog2(N + 1);
  localparam int IW     = $clog2(N);
  localparam int HI     = (255 << (8 - P)) & 255;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [7:0]    cfg_wdata;
  logic [7:0]    cfg_rdata;
  logic [N-1:0]  src_pend;
  logic [N-1:0]  src_en;
  logic          cur_thread;
  logic [7:0]    cur_grp;
  logic          preempt_req;
  logic [IW-1:0] win_idx;
  logic [7:0]    win_prio;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;
  int m_prio [N];
  int m_split;

  always #5 clk = ~clk;

  prio_resolver #(.NUM_SRC(N), .PRIO_BITS(P)) u_prio_resolver (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_pend(src_pend),
    .src_en(src_en), .cur_thread(cur_thread), .cur_grp(cur_grp),
    .preempt_req(preempt_req), .win_idx(win_idx), .win_prio(win_prio)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: expected values from model state before the edge.
  task automatic step(input string tag);
    int e_pre, e_idx, e_prio, e_rd, best, gm;
    e_pre = 0; e_idx = 0; e_prio = 0; e_rd = 0; best = -1;
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (src_pend[i] && src_en[i]) begin
          if (best < 0 || m_prio[i] < e_prio) begin
            best = i; e_prio = m_prio[i];
          end
        end
      end
      gm = 0;
      for (int b = 0; b < 8; b++) if (b > m_split) gm |= (1 << b);
      if (best >= 0) begin
        e_idx = best;
        e_pre = (cur_thread || ((e_prio & gm) < (int'(cur_grp) & gm))) ? 1 : 0;
      end
      if (int'(cfg_addr) < N) e_rd = m_prio[cfg_addr];
      else if (int'(cfg_addr) == N) e_rd = m_split;
      if (cfg_we) begin
        if (int'(cfg_addr) < N) m_prio[cfg_addr] = int'(cfg_wdata) & HI;
        else if (int'(cfg_addr) == N) m_split = int'(cfg_wdata) & 7;
      end
    end else begin
      for (int i = 0; i < N; i++) m_prio[i] = 0;
      m_split = 0;
    end
    @(negedge clk);
    chk(tag, "preempt_req", int'(preempt_req), e_pre);
    chk(tag, "win_idx", int'(win_idx), e_idx);
    chk(tag, "win_prio", int'(win_prio), e_prio);
    chk(tag, "cfg_rdata", int'(cfg_rdata), e_rd);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = 8'(d);
    step(tag);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    cfg_addr = AW'(a);
    step(tag);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    src_pend = '0; src_en = '0; cur_thread = 1'b0; cur_grp = 8'h00;
    @(negedge clk);
    repeat (3) step("R1");
    rst = 1'b0;
    for (int a = 0; a <= N; a++) rd(a, "R1");

    // R2: all-ones write reads back only implemented bits
    wr(3, 8'hFF, "R2");
    rd(3, "R2");
    wr(7, 8'h5A, "R2");
    rd(7, "R2");
    // R3: split readback keeps three bits
    wr(N, 8'hFD, "R3");
    rd(N, "R3");
    // R4: out-of-range writes ignored
    if ((1 << AW) > N + 1) begin
      wr(N + 1, 8'h03, "R4");
      rd(N + 1, "R4");
      for (int a = 0; a <= N; a++) rd(a, "R4");
    end

    // split 5: group [7:6], sub [5:4]
    wr(N, 5, "R3");
    wr(0, 8'h80, "R2"); wr(1, 8'h40, "R2"); wr(2, 8'h50, "R2"); wr(3, 8'h40, "R2");
    src_en = '1;
    src_pend = '0; step("R5");
    src_pend = 16'h0006; cur_grp = 8'h40; step("R9");
    cur_grp = 8'h80; step("R9");
    src_pend = 16'h000A; step("R6");
    src_pend = 16'h0005; cur_grp = 8'h7F; step("R10");
    cur_grp = 8'h40; step("R10");
    src_pend = 16'h0001; cur_thread = 1'b1; cur_grp = 8'h00; step("R8");
    cur_thread = 1'b0; step("R9");
    src_pend = '1; src_en = '0; step("R5");
    src_en = '1; src_pend = 16'h0003; cur_grp = 8'hC0;
    wr(0, 8'h00, "R7");
    step("R7");

    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      src_pend   = N'($urandom);
      src_en     = N'($urandom) | N'($urandom);
      cur_thread = ($urandom % 8) == 0;
      cur_grp    = 8'($urandom);
      cfg_addr   = AW'($urandom % (N + 2));
      cfg_wdata  = 8'($urandom);
      cfg_we     = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) src_pend = '0;
      step("R6");
    end
    cfg_we = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R7 actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule